// File: doc/BRIEF.md
# Paired Byte Queues with Programmable Receive Threshold

This block holds the byte queues that sit between a serial line engine and a processor bus. A receive queue collects bytes arriving from the line side and hands them to the reader in arrival order. A transmit queue collects bytes from the bus side for the line engine to drain. Each queue has its own push port and pop port. The head byte is always visible on the pop data output, and a pop advances past it.

A single 8-bit control word, written with a strobe, governs both queues.

- **Bit 0** switches deep mode on. With deep mode off, each queue holds one byte only, like a plain holding register.
- **Bits 1 and 2** are one-shot flush commands, bit 1 for the receive queue and bit 2 for the transmit queue.
- **Bit 3** is kept as a transfer-mode flag for logic outside the block.
- **Bits 7:6** pick how many stored receive bytes raise the data-ready flag.

The receive side also keeps a sticky overrun flag for bytes that were turned away because the queue was full.

Top module: `fifo_ctl_pair`

## Requirements
- R1: After reset, both queues are empty with count 0, deep mode is off (`fifo_on`=0), `dma_mode`=0, `rx_trig`=0 and `rx_overrun`=0.
- R2: Writing the control word with bit 0 = 1 turns on deep mode. Each queue then takes DEPTH bytes, and `*_full` rises when the count equals DEPTH.
- R3: A control write with bit 0 = 0 empties both queues and turns deep mode off. The effect is visible one cycle after the write. A write that switches bit 0 from 0 to 1 also empties both queues.
- R4: A control write with bit 1 = 1 empties only the receive queue, and one with bit 2 = 1 empties only the transmit queue. Any push or pop to a queue in its flush cycle is discarded.
- R5: The flush bits are never stored. A later control write with bits 1 and 2 at 0 and bit 0 unchanged at 1 leaves both queues' contents intact.
- R6: In deep mode, bits 7:6 select the receive threshold: 00 gives 1, 01 gives DEPTH/4, 10 gives DEPTH/2 and 11 gives DEPTH-2. `rx_trig` is high whenever the receive count is at or above the threshold.
- R7: Bit 3 of each control write is held on `dma_mode`. Bits 5 and 4 have no effect on any output.
- R8: With deep mode off, each queue holds at most one byte, `*_full` is high at count 1, and `rx_trig` is high at count 1 whatever bits 7:6 hold.
- R9: A push to a full receive queue with no pop in the same cycle drops the byte and sets `rx_overrun`. `rx_overrun` stays set until a cycle with `status_rd` high, and a new drop in that same cycle keeps it set.
- R10: A push and a pop in the same cycle on a non-empty queue leave its count unchanged. This holds when the queue is full, where the pushed byte is accepted.
- R11: Each queue presents its oldest byte on `*_pop_data` while non-empty. Bytes leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word value |
| status_rd | input | 1 | Status read; clears receive overrun |
| fifo_on | output | 1 | Deep mode is active |
| dma_mode | output | 1 | Latched transfer-mode flag |
| rx_push | input | 1 | Receive queue push |
| rx_push_data | input | W | Byte pushed into receive queue |
| rx_pop | input | 1 | Receive queue pop |
| rx_pop_data | output | W | Receive queue head byte |
| rx_count | output | CW | Receive queue occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_trig | output | 1 | Receive count at or above threshold |
| rx_overrun | output | 1 | Sticky receive drop flag |
| tx_push | input | 1 | Transmit queue push |
| tx_push_data | input | W | Byte pushed into transmit queue |
| tx_pop | input | 1 | Transmit queue pop |
| tx_pop_data | output | W | Transmit queue head byte |
| tx_count | output | CW | Transmit queue occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |

## Verification
The bench builds the block with its defaults, W=8 and DEPTH=16, which makes the four thresholds 1, 4, 8 and 14. With sixteen entries, the read and write pointers wrap many times during the random phase, so full-queue push-and-pop cycles and pointer wrap arrive in the same run. The one-byte mode keeps overrun and the threshold-of-one case only a push or two away, and random control writes flip between both capacities in mid-traffic.

// File: rtl/fifo_ctl_pkg.sv
package fifo_ctl_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_NEAR = 2'b11
  } trig_code_e;

  // Threshold in bytes for a code, scaled from the queue depth.
  function automatic int unsigned trig_level(trig_code_e code, int unsigned depth);
    int unsigned lvl;
    case (code)
      TRIG_ONE:  lvl = 1;
      TRIG_QTR:  lvl = depth / 4;
      TRIG_HALF: lvl = depth / 2;
      default:   lvl = depth - 2;
    endcase
    if (lvl < 1) lvl = 1;
    return lvl;
  endfunction

endpackage

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg
  import fifo_ctl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [7:0]    wdata,
  output logic          deep,
  output logic          dma_mode,
  output logic          flush_rx,
  output logic          flush_tx,
  output logic [CW-1:0] thr
);

  localparam int EN_B  = 0;
  localparam int RXF_B = 1;
  localparam int TXF_B = 2;
  localparam int DMA_B = 3;
  localparam int LV_LO = 6;

  trig_code_e code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      deep     <= 1'b0;
      dma_mode <= 1'b0;
      code_q   <= TRIG_ONE;
    end else if (we) begin
      deep     <= wdata[EN_B];
      dma_mode <= wdata[DMA_B];
      code_q   <= trig_code_e'(wdata[LV_LO+1:LV_LO]);
    end
  end

  // One-shot flushes: explicit command, disable, or a mode switch into deep.
  assign flush_rx = we && (wdata[RXF_B] || !wdata[EN_B] || !deep);
  assign flush_tx = we && (wdata[TXF_B] || !wdata[EN_B] || !deep);

  always_comb begin
    if (deep) thr = CW'(trig_level(code_q, DEPTH));
    else      thr = CW'(1);
  end

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(deep) && $stable(dma_mode)); // R7

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          deep,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          push_drop
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap       = deep ? CW'(DEPTH) : CW'(1);
  assign empty     = (count == '0);
  assign full      = (count == cap);
  assign pop_ok    = pop && !empty && !flush;
  assign push_ok   = push && !flush && (!full || pop_ok);
  assign push_drop = push && !flush && !push_ok;

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R2
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !deep |-> count <= CW'(1)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty); // R4
  AST_PUSHPOP_STEADY: assert property (@(posedge clk) disable iff (rst)
    push && pop && !empty && !flush |=> $stable(count)); // R10

endmodule

// File: rtl/fifo_rx_flags.sv
module fifo_rx_flags #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drop,
  input  logic          clr,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thr,
  output logic          overrun,
  output logic          trig
);

  always_ff @(posedge clk) begin
    if (rst)       overrun <= 1'b0;
    else if (drop) overrun <= 1'b1;
    else if (clr)  overrun <= 1'b0;
  end

  assign trig = (count >= thr);

  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    drop |=> overrun); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun && !clr |=> overrun); // R9

endmodule

// File: rtl/fifo_ctl_pair.sv
module fifo_ctl_pair #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          status_rd,
  output logic          fifo_on,
  output logic          dma_mode,
  input  logic          rx_push,
  input  logic [W-1:0]  rx_push_data,
  input  logic          rx_pop,
  output logic [W-1:0]  rx_pop_data,
  output logic [CW-1:0] rx_count,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          rx_trig,
  output logic          rx_overrun,
  input  logic          tx_push,
  input  logic [W-1:0]  tx_push_data,
  input  logic          tx_pop,
  output logic [W-1:0]  tx_pop_data,
  output logic [CW-1:0] tx_count,
  output logic          tx_empty,
  output logic          tx_full
);

  logic          flush_rx, flush_tx, rx_drop, tx_drop_unused;
  logic [CW-1:0] thr;

  fifo_ctl_reg #(.DEPTH(DEPTH), .CW(CW)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .deep(fifo_on), .dma_mode(dma_mode),
    .flush_rx(flush_rx), .flush_tx(flush_tx), .thr(thr)
  );

  fifo_store #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_rxq (
    .clk(clk), .rst(rst), .deep(fifo_on), .flush(flush_rx),
    .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
    .pop_data(rx_pop_data), .count(rx_count), .empty(rx_empty),
    .full(rx_full), .push_drop(rx_drop)
  );

  fifo_store #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_txq (
    .clk(clk), .rst(rst), .deep(fifo_on), .flush(flush_tx),
    .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
    .pop_data(tx_pop_data), .count(tx_count), .empty(tx_empty),
    .full(tx_full), .push_drop(tx_drop_unused)
  );

  fifo_rx_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst(rst), .drop(rx_drop), .clr(status_rd),
    .count(rx_count), .thr(thr), .overrun(rx_overrun), .trig(rx_trig)
  );

  AST_TRIG_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_trig |-> !rx_empty); // R6
  AST_OFF_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    ctl_we && !ctl_wdata[0] |=> rx_empty && tx_empty && !fifo_on); // R3

endmodule

// File: tb/fifo_ctl_pair_test.sv
module fifo_ctl_pair_test;
  localparam int W = 8, DEPTH = 16, CW = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic ctl_we = 0, status_rd = 0, rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [7:0] ctl_wdata = 0;
  logic [W-1:0] rx_push_data = 0, tx_push_data = 0;
  logic fifo_on, dma_mode, rx_empty, rx_full, rx_trig, rx_overrun, tx_empty, tx_full;
  logic [W-1:0] rx_pop_data, tx_pop_data;
  logic [CW-1:0] rx_count, tx_count;

  int checks = 0, errors = 0;
  bit m_en = 0, m_dma = 0, m_ovr = 0;
  int m_lvl = 0;
  logic [W-1:0] rxq[$], txq[$];

  always #5 clk = ~clk;

  fifo_ctl_pair #(.W(W), .DEPTH(DEPTH)) uut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int thr_of(bit en, int lvl);
    if (!en) return 1;
    case (lvl)
      0: return 1;
      1: return DEPTH / 4;
      2: return DEPTH / 2;
      default: return DEPTH - 2;
    endcase
  endfunction

  task automatic model_q(ref logic [W-1:0] q[$], input bit fl, input bit pu,
                         input logic [W-1:0] d, input bit po, output bit drop);
    int cap = m_en ? DEPTH : 1;
    bit pop_ok, push_ok;
    drop = 0;
    if (fl) begin q.delete(); return; end
    pop_ok  = po && q.size() > 0;
    push_ok = pu && (q.size() < cap || pop_ok);
    drop    = pu && !push_ok;
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(d);
  endtask

  task automatic model_update();
    bit frx, ftx, drop, dtx;
    frx = ctl_we && (ctl_wdata[1] || !ctl_wdata[0] || !m_en);
    ftx = ctl_we && (ctl_wdata[2] || !ctl_wdata[0] || !m_en);
    model_q(rxq, frx, rx_push, rx_push_data, rx_pop, drop);
    model_q(txq, ftx, tx_push, tx_push_data, tx_pop, dtx);
    if (drop) m_ovr = 1;
    else if (status_rd) m_ovr = 0;
    if (ctl_we) begin
      m_en = ctl_wdata[0]; m_dma = ctl_wdata[3]; m_lvl = ctl_wdata[7:6];
    end
  endtask

  task automatic compare(string tag);
    int cap = m_en ? DEPTH : 1;
    chk(tag, "rx_count", rx_count, rxq.size());
    chk(tag, "tx_count", tx_count, txq.size());
    chk(tag, "rx_empty", rx_empty, rxq.size() == 0);
    chk(tag, "tx_empty", tx_empty, txq.size() == 0);
    chk(tag, "rx_full", rx_full, rxq.size() == cap);
    chk(tag, "tx_full", tx_full, txq.size() == cap);
    chk(tag, "rx_trig", rx_trig, rxq.size() >= thr_of(m_en, m_lvl));
    chk(tag, "rx_overrun", rx_overrun, m_ovr);
    chk(tag, "fifo_on", fifo_on, m_en);
    chk(tag, "dma_mode", dma_mode, m_dma);
    if (rxq.size() > 0) chk(tag, "rx_head", rx_pop_data, rxq[0]);
    if (txq.size() > 0) chk(tag, "tx_head", tx_pop_data, txq[0]);
  endtask

  task automatic step(string tag);
    model_update();
    @(posedge clk); #1;
    compare(tag);
    ctl_we = 0; status_rd = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  task automatic wr_ctl(logic [7:0] v, string tag);
    ctl_we = 1; ctl_wdata = v; step(tag);
  endtask

  task automatic push_rx(logic [W-1:0] d, string tag);
    rx_push = 1; rx_push_data = d; step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1", "rx_count", rx_count, 0);
    chk("R1", "tx_count", tx_count, 0);
    chk("R1", "fifo_on", fifo_on, 0);
    chk("R1", "rx_trig", rx_trig, 0);
    chk("R1", "rx_overrun", rx_overrun, 0);
    chk("R1", "dma_mode", dma_mode, 0);
    chk("R1", "rx_empty", rx_empty, 1);
    // R8 single-byte mode: second push dropped, trig at one byte
    wr_ctl(8'hC0, "R8");
    push_rx(8'h11, "R8");
    push_rx(8'h22, "R9");
    status_rd = 1; step("R9");
    // R3 switching to deep empties queues
    wr_ctl(8'h01, "R3");
    // R2 fill to DEPTH, R9 overflow
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i + 8'h40), "R2");
    push_rx(8'hEE, "R9");
    push_rx(8'hEF, "R9");
    rx_push = 1; rx_push_data = 8'hAB; status_rd = 1; step("R9");
    status_rd = 1; step("R9");
    // R10 push and pop on a full queue
    rx_push = 1; rx_push_data = 8'h5A; rx_pop = 1; step("R10");
    // R11 drain in order
    for (int i = 0; i < 4; i++) begin rx_pop = 1; step("R11"); end
    // R4 selective flush with R7 ignored bits
    for (int i = 0; i < 5; i++) begin tx_push = 1; tx_push_data = 8'(i * 7); step("R4"); end
    wr_ctl(8'h03, "R4");
    push_rx(8'h77, "R4");
    wr_ctl(8'h01, "R5");
    wr_ctl(8'h31, "R7");
    wr_ctl(8'h09, "R7");
    wr_ctl(8'h05, "R4");
    rx_push = 1; tx_push = 1; wr_ctl(8'h07, "R4");
    // R6 each threshold code
    for (int c = 0; c < 4; c++) begin
      wr_ctl(8'((c << 6) | 1), "R6");
      for (int i = 0; i < DEPTH; i++) push_rx(8'(c * 16 + i), "R6");
      wr_ctl(8'((c << 6) | 3), "R6");
    end
    // R3 disabling with contents
    push_rx(8'h99, "R3");
    tx_push = 1; step("R3");
    wr_ctl(8'h00, "R3");
    wr_ctl(8'h01, "R3");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      rx_push = 1'($urandom % 2);
      rx_pop  = ($urandom % 3) == 0;
      tx_push = 1'($urandom % 2);
      tx_pop  = 1'($urandom % 2);
      rx_push_data = 8'($urandom);
      tx_push_data = 8'($urandom);
      status_rd = ($urandom % 10) == 0;
      if (($urandom % 40) == 0) begin
        ctl_we = 1;
        ctl_wdata = 8'($urandom);
        if (($urandom % 8) != 0) ctl_wdata[0] = 1'b1;
      end
      step("R11");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule